// File: doc/BRIEF.md
# Ping-Pong Page Buffer

A 32-byte store split into two 16-byte pages, shared between a user port and an internal sequencer port. Each port drives only a 4-bit offset. The page bit is supplied from inside the block, so the two sides always work on opposite pages. The user fills or inspects one page while the sequencer moves the other page to or from its backing medium.

The sequencer asks for an exchange of pages by pulsing `swapReq`. It pulses it when a page-write command starts, so the user can load the next page at once. It pulses it again when a page-read command ends, so the fetched data appears on the user side. The request is carried into the user clock as a toggle through a synchronizer. The acknowledge comes back the same way, and `swapBusy` stays high until the exchange has reached both sides. No page changes hands except through a swap. A page fetched by the sequencer therefore stays readable and editable in place by the user until the next swap, which supports read-modify-write.

Top module: `pageBuffer`

## Requirements
- R1: After reset every byte reads 0 on both ports. The user side works on page 0 and the sequencer side on page 1.
- R2: A user write takes effect when `userCe` and `userWe` are both high at a `userClk` edge. A user read presents the addressed byte on `userRdata` one `userClk` edge after `userCe` is sampled high. When the same edge also writes, the read returns the byte's value from before that write.
- R3: While `userCe` is low, `userRdata` holds its value, whatever the address does.
- R4: `userWe` with `userCe` low writes nothing.
- R5: The sequencer port writes when `seqEn` and `seqWe` are high at a `seqClk` edge. It reads with one edge of latency when `seqEn` is high. With `seqEn` low it neither writes nor changes `seqRdata`.
- R6: Between swaps, the two ports address opposite pages. Writes on one side at any offset leave the other side's bytes at every offset unchanged.
- R7: After an accepted swap completes, the user side sees the page the sequencer had, and the sequencer side sees the page the user had. Contents are unchanged.
- R8: A `swapReq` that arrives while `swapBusy` is high is ignored. Each accepted request exchanges the pages exactly once.
- R9: Page contents persist across any number of accesses without a swap, so bytes read by the user can be modified in place and read back.
- R10: `swapBusy` is high at the `seqClk` edge after an accepted request. It falls within 12 `seqClk` cycles when `userClk` is no slower than `seqClk`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rstN | input | 1 | Asynchronous active-low reset for both domains |
| userClk | input | 1 | User port clock |
| userCe | input | 1 | User access enable |
| userWe | input | 1 | User write enable (qualified by userCe) |
| userAddr | input | 4 | Byte offset within the user's page |
| userWdata | input | 8 | User write data |
| userRdata | output | 8 | Registered user read data |
| seqClk | input | 1 | Sequencer port clock |
| seqEn | input | 1 | Sequencer access enable |
| seqWe | input | 1 | Sequencer write enable (qualified by seqEn) |
| seqAddr | input | 4 | Byte offset within the sequencer's page |
| seqWdata | input | 8 | Sequencer write data |
| seqRdata | output | 8 | Registered sequencer read data |
| swapReq | input | 1 | One-cycle request to exchange pages (seqClk domain) |
| swapBusy | output | 1 | Swap in flight; new requests are ignored |

## Verification
The bench uses the default parameters: 8-bit bytes, 4-bit page offsets and a two-stage synchronizer. This is small enough that every offset of both pages is written and read back from both ports, before and after each swap. The two clocks are unrelated, with periods of 10 and 14 time units. The toggle handshake is therefore exercised with real phase drift, including a second request raised while a swap is still in flight. A bench model of the page ownership predicts every byte through two swaps, a rejected swap and in-place edits.

// File: rtl/pageBufPkg.sv
package pageBufPkg;
  typedef struct packed {
    logic rd;
    logic wr;
    logic page;
  } portStb_t;
endpackage

// File: rtl/pageCtrl.sv
module pageCtrl
  import pageBufPkg::*;
#(
  parameter int SYNC_DEPTH = 2
) (
  input  logic     rstN,
  input  logic     userClk,
  input  logic     userCe,
  input  logic     userWe,
  input  logic     seqClk,
  input  logic     seqEn,
  input  logic     seqWe,
  input  logic     swapReq,
  output logic     swapBusy,
  output portStb_t userStb,
  output portStb_t seqStb
);
  localparam int TOP = SYNC_DEPTH - 1;

  logic                  reqTgl;
  logic [SYNC_DEPTH-1:0] userSync;
  logic [SYNC_DEPTH-1:0] ackSync;
  logic                  userPage;
  logic                  ackTgl;

  // request toggle lives in the sequencer domain
  always_ff @(posedge seqClk or negedge rstN) begin
    if (!rstN) reqTgl <= 1'b0;
    else if (swapReq && !swapBusy) reqTgl <= ~reqTgl;
  end

  // carry the toggle into the user domain; its settled value is the user page
  always_ff @(posedge userClk or negedge rstN) begin
    if (!rstN) userSync <= '0;
    else       userSync <= {userSync[TOP-1:0], reqTgl};
  end
  assign userPage = userSync[TOP];

  // return the user page to the sequencer domain as the acknowledge
  always_ff @(posedge seqClk or negedge rstN) begin
    if (!rstN) ackSync <= '0;
    else       ackSync <= {ackSync[TOP-1:0], userPage};
  end
  assign ackTgl = ackSync[TOP];

  assign swapBusy = reqTgl ^ ackTgl;

  always_comb begin
    userStb.rd   = userCe;
    userStb.wr   = userCe & userWe;
    userStb.page = userPage;
    seqStb.rd    = seqEn;
    seqStb.wr    = seqEn & seqWe;
    seqStb.page  = ~ackTgl;
  end
endmodule

// File: rtl/pageStore.sv
module pageStore
  import pageBufPkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int PAGE_AW = 4
) (
  input  logic              rstN,
  input  logic              userClk,
  input  portStb_t          userStb,
  input  logic [PAGE_AW-1:0] userAddr,
  input  logic [DATA_W-1:0] userWdata,
  output logic [DATA_W-1:0] userRdata,
  input  logic              seqClk,
  input  portStb_t          seqStb,
  input  logic [PAGE_AW-1:0] seqAddr,
  input  logic [DATA_W-1:0] seqWdata,
  output logic [DATA_W-1:0] seqRdata
);
  localparam int AW    = PAGE_AW + 1;
  localparam int DEPTH = 1 << AW;

  // Each port owns one array; a byte's value is the XOR of both copies,
  // so every array has a single writer in a single clock domain.
  logic [DATA_W-1:0] userArr [DEPTH];
  logic [DATA_W-1:0] seqArr  [DEPTH];
  logic [AW-1:0]     userIdx;
  logic [AW-1:0]     seqIdx;

  assign userIdx = {userStb.page, userAddr};
  assign seqIdx  = {seqStb.page, seqAddr};

  always_ff @(posedge userClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) userArr[i] <= '0;
      userRdata <= '0;
    end else begin
      if (userStb.wr) userArr[userIdx] <= userWdata ^ seqArr[userIdx];
      if (userStb.rd) userRdata <= userArr[userIdx] ^ seqArr[userIdx];
    end
  end

  always_ff @(posedge seqClk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) seqArr[i] <= '0;
      seqRdata <= '0;
    end else begin
      if (seqStb.wr) seqArr[seqIdx] <= seqWdata ^ userArr[seqIdx];
      if (seqStb.rd) seqRdata <= seqArr[seqIdx] ^ userArr[seqIdx];
    end
  end
endmodule

// File: rtl/pageBuffer.sv
module pageBuffer
  import pageBufPkg::*;
#(
  parameter int DATA_W     = 8,
  parameter int PAGE_AW    = 4,
  parameter int SYNC_DEPTH = 2
) (
  input  logic               rstN,
  input  logic               userClk,
  input  logic               userCe,
  input  logic               userWe,
  input  logic [PAGE_AW-1:0] userAddr,
  input  logic [DATA_W-1:0]  userWdata,
  output logic [DATA_W-1:0]  userRdata,
  input  logic               seqClk,
  input  logic               seqEn,
  input  logic               seqWe,
  input  logic [PAGE_AW-1:0] seqAddr,
  input  logic [DATA_W-1:0]  seqWdata,
  output logic [DATA_W-1:0]  seqRdata,
  input  logic               swapReq,
  output logic               swapBusy
);
  portStb_t userStb;
  portStb_t seqStb;

  pageCtrl #(.SYNC_DEPTH(SYNC_DEPTH)) u_ctrl (
    .rstN(rstN), .userClk(userClk), .userCe(userCe), .userWe(userWe),
    .seqClk(seqClk), .seqEn(seqEn), .seqWe(seqWe), .swapReq(swapReq),
    .swapBusy(swapBusy), .userStb(userStb), .seqStb(seqStb)
  );

  pageStore #(.DATA_W(DATA_W), .PAGE_AW(PAGE_AW)) u_store (
    .rstN(rstN), .userClk(userClk), .userStb(userStb), .userAddr(userAddr),
    .userWdata(userWdata), .userRdata(userRdata), .seqClk(seqClk),
    .seqStb(seqStb), .seqAddr(seqAddr), .seqWdata(seqWdata),
    .seqRdata(seqRdata)
  );
endmodule

// File: rtl/pageBufChecker.sv
module pageBufChecker #(
  parameter int DATA_W = 8
) (
  input logic              rstN,
  input logic              userClk,
  input logic              seqClk,
  input logic              userCe,
  input logic              seqEn,
  input logic              swapReq,
  input logic              swapBusy,
  input logic              userPage,
  input logic              seqPage,
  input logic [DATA_W-1:0] userRdata,
  input logic [DATA_W-1:0] seqRdata
);
  // R10: an accepted request raises busy at the next sequencer edge
  p_busy_rise_r10: assert property (@(posedge seqClk) disable iff (!rstN)
    (swapReq && !swapBusy) |=> swapBusy);

  // R8 / R7: with no swap in flight and none requested, the sequencer page holds
  p_page_hold_r8: assert property (@(posedge seqClk) disable iff (!rstN)
    (!swapBusy && !swapReq) |=> $stable(seqPage));

  // R6: when idle the two sides sit on opposite pages
  p_opposite_r6: assert property (@(posedge seqClk) disable iff (!rstN)
    !swapBusy |-> (seqPage != userPage));

  // R3: user read data holds while the enable is low
  p_user_hold_r3: assert property (@(posedge userClk) disable iff (!rstN)
    !userCe |=> $stable(userRdata));

  // R5: sequencer read data holds while its enable is low
  p_seq_hold_r5: assert property (@(posedge seqClk) disable iff (!rstN)
    !seqEn |=> $stable(seqRdata));
endmodule

bind pageBuffer pageBufChecker #(.DATA_W(DATA_W)) u_chk (
  .rstN(rstN), .userClk(userClk), .seqClk(seqClk), .userCe(userCe),
  .seqEn(seqEn), .swapReq(swapReq), .swapBusy(swapBusy),
  .userPage(userStb.page), .seqPage(seqStb.page),
  .userRdata(userRdata), .seqRdata(seqRdata)
);

// File: tb/sim_pageBuffer.sv
module sim_pageBuffer;
  localparam int CLK_PERIOD = 10;
  localparam int SEQ_PERIOD = 14;

  logic       rstN = 1'b0;
  logic       userClk = 1'b0;
  logic       seqClk = 1'b0;
  logic       userCe = 1'b0, userWe = 1'b0;
  logic [3:0] userAddr = '0;
  logic [7:0] userWdata = '0;
  logic [7:0] userRdata;
  logic       seqEn = 1'b0, seqWe = 1'b0;
  logic [3:0] seqAddr = '0;
  logic [7:0] seqWdata = '0;
  logic [7:0] seqRdata;
  logic       swapReq = 1'b0;
  logic       swapBusy;

  int total = 0;
  int bad = 0;
  logic [7:0] model [32];
  logic       upage = 1'b0;
  logic       done = 1'b0;

  always #(CLK_PERIOD/2) userClk = ~userClk;
  always #(SEQ_PERIOD/2) seqClk = ~seqClk;

  pageBuffer u0 (
    .rstN(rstN), .userClk(userClk), .userCe(userCe), .userWe(userWe),
    .userAddr(userAddr), .userWdata(userWdata), .userRdata(userRdata),
    .seqClk(seqClk), .seqEn(seqEn), .seqWe(seqWe), .seqAddr(seqAddr),
    .seqWdata(seqWdata), .seqRdata(seqRdata), .swapReq(swapReq),
    .swapBusy(swapBusy)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic uWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge userClk); userCe = 1; userWe = 1; userAddr = a; userWdata = d;
    @(negedge userClk); userCe = 0; userWe = 0;
    model[{upage, a}] = d;
  endtask

  task automatic uRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge userClk); userCe = 1; userWe = 0; userAddr = a;
    @(negedge userClk); userCe = 0; d = userRdata;
  endtask

  task automatic sWrite(input logic [3:0] a, input logic [7:0] d);
    @(negedge seqClk); seqEn = 1; seqWe = 1; seqAddr = a; seqWdata = d;
    @(negedge seqClk); seqEn = 0; seqWe = 0;
    model[{~upage, a}] = d;
  endtask

  task automatic sRead(input logic [3:0] a, output logic [7:0] d);
    @(negedge seqClk); seqEn = 1; seqWe = 0; seqAddr = a;
    @(negedge seqClk); seqEn = 0; d = seqRdata;
  endtask

  task automatic doSwap(input logic second);
    int n;
    @(negedge seqClk); swapReq = 1;
    @(negedge seqClk); swapReq = 0;
    check("R10 busy after request", {7'd0, swapBusy}, 8'd1);
    if (second) begin
      swapReq = 1;               // arrives while busy: must be ignored (R8)
      @(negedge seqClk); swapReq = 0;
    end
    n = 0;
    while (swapBusy && n < 12) begin @(negedge seqClk); n++; end
    check("R10 busy falls in time", {7'd0, swapBusy}, 8'd0);
    upage = ~upage;
    repeat (3) @(negedge seqClk);
  endtask

  task automatic sweepBoth(input string req);
    logic [7:0] d;
    for (int a = 0; a < 16; a++) begin
      uRead(4'(a), d); check({req, " user"}, d, model[{upage, 4'(a)}]);
      sRead(4'(a), d); check({req, " seq"}, d, model[{~upage, 4'(a)}]);
    end
  endtask

  initial begin
    logic [7:0] d, keep;
    for (int i = 0; i < 32; i++) model[i] = 8'h00;
    repeat (3) @(negedge userClk);
    rstN = 1;
    repeat (3) @(negedge seqClk);

    sweepBoth("R1 reset");

    for (int a = 0; a < 16; a++) uWrite(4'(a), 8'((a * 17 + 3) & 8'hff));
    sweepBoth("R6 after user fill");
    for (int a = 0; a < 16; a++) sWrite(4'(a), 8'((a * 29 + 8'h5a) & 8'hff));
    sweepBoth("R5 R2 after seq fill");

    // R2: read-before-write on the same edge
    @(negedge userClk); userCe = 1; userWe = 1; userAddr = 4'd5; userWdata = 8'hc3;
    @(negedge userClk); userCe = 0; userWe = 0;
    check("R2 old value on write", userRdata, model[{upage, 4'd5}]);
    model[{upage, 4'd5}] = 8'hc3;
    uRead(4'd5, d); check("R2 written value", d, 8'hc3);

    // R3: enable low, address moves, data holds
    keep = userRdata;
    @(negedge userClk); userAddr = 4'd9;
    repeat (3) @(negedge userClk);
    check("R3 hold with ce low", userRdata, keep);

    // R4: write enable without ce
    @(negedge userClk); userWe = 1; userAddr = 4'd2; userWdata = 8'hee;
    @(negedge userClk); userWe = 0;
    uRead(4'd2, d); check("R4 no write without ce", d, model[{upage, 4'd2}]);

    // R5: sequencer write enable without seqEn
    @(negedge seqClk); seqWe = 1; seqAddr = 4'd7; seqWdata = 8'h11;
    @(negedge seqClk); seqWe = 0;
    sRead(4'd7, d); check("R5 no write without en", d, model[{~upage, 4'd7}]);

    doSwap(1'b0);
    sweepBoth("R7 after first swap");

    doSwap(1'b1);
    sweepBoth("R8 single flip for double request");

    // R9: read-modify-write in place on the user page
    for (int a = 0; a < 16; a += 3) begin
      uRead(4'(a), d);
      uWrite(4'(a), d ^ 8'h80);
      sWrite(4'(a), 8'(a));
    end
    sweepBoth("R9 edits persist");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge userClk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=%h expected=%h", 8'd0, 8'd1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule